// File: doc/BRIEF.md
# Response Ring Dispatcher

This block empties a 256-slot ring of replies that a link controller fills. It watches the hardware write pointer. When that pointer moves, it walks its own read pointer forward one slot per clock until the two meet. Each slot is 64 bits wide: the lower word is the reply payload and the upper word carries routing information. The block reads each slot and sends it to one of four places:

- Unsolicited events go out on a ready/valid event stream.
- Replies that answer a command are saved as the latest reply for their target.
- Replies with an invalid target are reported as spurious.
- Replies for a target that has no command outstanding are also reported as spurious.

The command producer raises an increment strobe each time it issues a command to a target. The dispatcher lowers that target's count when a matching reply arrives. A requester polls a target through a query port. The port shows whether all of that target's commands have been answered, and gives the last reply saved for it. The ring storage itself sits outside the block. The block presents a slot index and gets the 64-bit slot contents back in the same cycle.

Top module: `rsp_ring_drain`

## Requirements
- R1: A slot is read as follows. Bits 31:0 are the reply payload and bits 63:32 are the routing word. Routing bits 3:0 are the target number and routing bit 4 is set for an unsolicited event. Routing bits 31:5 do not affect classification.
- R2: Suppose the block is idle and the low 8 bits of `hw_wp` differ from the last latched pointer. The block then latches them. Starting on the next clock it consumes slots (read pointer + 1) mod 256 in order, at most one per clock, and stops when the read pointer equals the latched value. `rd_idx` always shows read pointer + 1.
- R3: A `hw_wp` value of 16'hFFFF is never latched. Read pointer, counts and stored replies stay unchanged.
- R4: A slot whose target is valid and whose unsolicited bit is set appears on `evt_valid` with its payload and routing word. It is consumed only in a cycle where `evt_ready` is 1. While it waits, no later slot is consumed.
- R5: A slot whose target number is NUM_TGT (4) or above is spurious whatever its unsolicited bit. It gives a one-cycle `spur_valid` with `spur_bad_tgt` = 1 and `spur_tgt` = the target, and it changes no count or reply.
- R6: A non-event slot whose target has a non-zero outstanding count stores its payload as that target's latest reply, and the count drops by one.
- R7: A non-event slot whose target has a zero count gives a one-cycle `spur_valid` with `spur_bad_tgt` = 0. Its payload is discarded.
- R8: `cmd_inc` adds one to the count of `cmd_tgt`. If an increment and a reply decrement hit the same target in the same cycle, the count is unchanged.
- R9: `qry_done` is 1 exactly when the count of `qry_tgt` is zero. `qry_resp` always shows that target's latest stored reply.
- R10: After reset, the read pointer and latched pointer are 0 (so `rd_idx` = 1), all counts and stored replies are 0, and `evt_valid` and `spur_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hw_wp | input | 16 | Hardware write pointer of the ring |
| rd_idx | output | 8 | Ring slot being examined |
| rd_entry | input | 64 | Contents of slot `rd_idx` |
| cmd_inc | input | 1 | Command issued strobe |
| cmd_tgt | input | 2 | Target of the issued command |
| evt_valid | output | 1 | Unsolicited event present |
| evt_ready | input | 1 | Event sink accepts |
| evt_resp | output | 32 | Event payload |
| evt_ext | output | 32 | Event routing word |
| spur_valid | output | 1 | Spurious slot seen (one cycle) |
| spur_bad_tgt | output | 1 | 1: invalid target, 0: no outstanding command |
| spur_tgt | output | 4 | Target field of the spurious slot |
| qry_tgt | input | 2 | Target being polled |
| qry_done | output | 1 | Polled target has nothing outstanding |
| qry_resp | output | 32 | Latest reply for the polled target |

## Verification
The bench sweeps every 4-bit target code. For each one it tries both values of the unsolicited flag, with and without an outstanding command, and puts unrelated bits in the upper routing word. A design that checks the unsolicited flag before the target range would send invalid targets out as events. A design that stores replies regardless of count would overwrite saved replies with orphans. A long batch that wraps past slot 255, with its drain time measured, catches a pointer that does not wrap, that skips a slot, or that moves more than once per clock. Three more tests cover the remaining corners:
- A stalled event sink must freeze the ring.
- A write pointer of all ones must be ignored.
- An increment landing in the same cycle as a reply decrement must leave the count unchanged, so completion is reported one reply later than a decrement-only design would report it.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;

    localparam int EXT_TGT_W     = 4;
    localparam int EXT_UNSOL_BIT = 4;

    typedef struct packed {
        logic [31:0] ext;
        logic [31:0] resp;
    } ring_entry_t;

    typedef enum logic [1:0] {
        KIND_EVENT,
        KIND_REPLY,
        KIND_BADTGT,
        KIND_ORPHAN
    } entry_kind_t;

endpackage

// File: rtl/rsp_entry_classify.sv
module rsp_entry_classify
    import rsp_ring_pkg::*;
#(
    parameter  int NUM_TGT = 4,
    localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic [EXT_UNSOL_BIT:0] ext_lo,
    input  logic [NUM_TGT-1:0]     pend_nz,
    output entry_kind_t            kind,
    output logic [EXT_TGT_W-1:0]   tgt
);

    // Range check first: an invalid target is spurious whatever the flag says.
    always_comb begin
        tgt = ext_lo[EXT_TGT_W-1:0];
        if (int'(tgt) >= NUM_TGT)
            kind = KIND_BADTGT;
        else if (ext_lo[EXT_UNSOL_BIT])
            kind = KIND_EVENT;
        else if (pend_nz[tgt[TGT_W-1:0]])
            kind = KIND_REPLY;
        else
            kind = KIND_ORPHAN;
    end

endmodule

// File: rtl/rsp_tgt_track.sv
module rsp_tgt_track #(
    parameter  int NUM_TGT = 4,
    parameter  int CNT_W   = 8,
    parameter  int RESP_W  = 32,
    localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic [TGT_W-1:0]  inc_tgt,
    input  logic              dec_en,
    input  logic [TGT_W-1:0]  dec_tgt,
    input  logic [RESP_W-1:0] dec_resp,
    input  logic [TGT_W-1:0]  qry_tgt,
    output logic [NUM_TGT-1:0] pend_nz,
    output logic              qry_done,
    output logic [RESP_W-1:0] qry_resp
);

    typedef struct packed {
        logic [NUM_TGT-1:0][CNT_W-1:0]  cnt;
        logic [NUM_TGT-1:0][RESP_W-1:0] resp;
    } track_st_t;

    track_st_t st_d, st_q;
    logic [NUM_TGT-1:0] inc_hit;
    logic [NUM_TGT-1:0] dec_hit;

    for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
        assign inc_hit[i] = inc_en && (inc_tgt == TGT_W'(i));
        assign dec_hit[i] = dec_en && (dec_tgt == TGT_W'(i));
        assign pend_nz[i] = (st_q.cnt[i] != '0);

        // R6: a decrement is only issued against a pending target
        p_dec_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
            dec_hit[i] |-> st_q.cnt[i] != '0);

        // R8: increment and decrement together cancel
        p_inc_dec_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_hit[i] && dec_hit[i]) |=> st_q.cnt[i] == $past(st_q.cnt[i]));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (inc_hit[i] && !dec_hit[i])
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            else if (dec_hit[i] && !inc_hit[i])
                st_d.cnt[i] = st_q.cnt[i] - 1'b1;
            if (dec_hit[i])
                st_d.resp[i] = dec_resp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign qry_done = (st_q.cnt[qry_tgt] == '0);
    assign qry_resp = st_q.resp[qry_tgt];

endmodule

// File: rtl/rsp_ring_drain.sv
module rsp_ring_drain
    import rsp_ring_pkg::*;
#(
    parameter  int RING_AW = 8,
    parameter  int NUM_TGT = 4,
    parameter  int CNT_W   = 8,
    parameter  int WP_W    = 16,
    localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WP_W-1:0]      hw_wp,
    output logic [RING_AW-1:0]   rd_idx,
    input  logic [63:0]          rd_entry,
    input  logic                 cmd_inc,
    input  logic [TGT_W-1:0]     cmd_tgt,
    output logic                 evt_valid,
    input  logic                 evt_ready,
    output logic [31:0]          evt_resp,
    output logic [31:0]          evt_ext,
    output logic                 spur_valid,
    output logic                 spur_bad_tgt,
    output logic [EXT_TGT_W-1:0] spur_tgt,
    input  logic [TGT_W-1:0]     qry_tgt,
    output logic                 qry_done,
    output logic [31:0]          qry_resp
);

    localparam logic [WP_W-1:0] WP_DEAD = '1;

    typedef struct packed {
        logic [RING_AW-1:0]   rp;
        logic [RING_AW-1:0]   seen;
        logic                 spur_v;
        logic                 spur_bad;
        logic [EXT_TGT_W-1:0] spur_tgt;
    } drain_st_t;

    drain_st_t            st_d, st_q;
    ring_entry_t          ent;
    entry_kind_t          kind;
    logic [EXT_TGT_W-1:0] ent_tgt;
    logic [NUM_TGT-1:0]   pend_nz;
    logic                 busy;
    logic                 consume;
    logic                 dec_en;

    assign ent    = rd_entry;
    assign rd_idx = st_q.rp + 1'b1;

    rsp_entry_classify #(.NUM_TGT(NUM_TGT)) u_classify (
        .ext_lo  (ent.ext[EXT_UNSOL_BIT:0]),
        .pend_nz (pend_nz),
        .kind    (kind),
        .tgt     (ent_tgt)
    );

    rsp_tgt_track #(.NUM_TGT(NUM_TGT), .CNT_W(CNT_W), .RESP_W(32)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_en   (cmd_inc),
        .inc_tgt  (cmd_tgt),
        .dec_en   (dec_en),
        .dec_tgt  (ent_tgt[TGT_W-1:0]),
        .dec_resp (ent.resp),
        .qry_tgt  (qry_tgt),
        .pend_nz  (pend_nz),
        .qry_done (qry_done),
        .qry_resp (qry_resp)
    );

    always_comb begin
        busy     = (st_q.rp != st_q.seen);
        consume  = busy && ((kind != KIND_EVENT) || evt_ready);
        dec_en   = consume && (kind == KIND_REPLY);
        st_d          = st_q;
        st_d.spur_v   = 1'b0;
        st_d.spur_bad = 1'b0;
        // A new pointer is only taken once the previous batch is drained.
        if (!busy && (hw_wp != WP_DEAD) && (hw_wp[RING_AW-1:0] != st_q.seen))
            st_d.seen = hw_wp[RING_AW-1:0];
        if (consume) begin
            st_d.rp = st_q.rp + 1'b1;
            if ((kind == KIND_BADTGT) || (kind == KIND_ORPHAN)) begin
                st_d.spur_v   = 1'b1;
                st_d.spur_bad = (kind == KIND_BADTGT);
                st_d.spur_tgt = ent_tgt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign evt_valid    = busy && (kind == KIND_EVENT);
    assign evt_resp     = ent.resp;
    assign evt_ext      = ent.ext;
    assign spur_valid   = st_q.spur_v;
    assign spur_bad_tgt = st_q.spur_bad;
    assign spur_tgt     = st_q.spur_tgt;

    p_rp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.rp) |-> st_q.rp == $past(st_q.rp) + 1'b1);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(st_q.rp));

    p_dead_wp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hw_wp == WP_DEAD) |=> $stable(st_q.seen) && $stable(st_q.rp));

    p_evt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> $stable(st_q.rp));

    p_spur_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spur_valid |-> $past(busy) && !$past(evt_valid));

endmodule

// File: tb/rsp_ring_drain_bench.sv
module rsp_ring_drain_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hw_wp = '0;
    logic [7:0]  rd_idx;
    logic [63:0] rd_entry;
    logic        cmd_inc = 1'b0;
    logic [1:0]  cmd_tgt = '0;
    logic        evt_valid;
    logic        evt_ready = 1'b1;
    logic [31:0] evt_resp, evt_ext;
    logic        spur_valid, spur_bad_tgt;
    logic [3:0]  spur_tgt;
    logic [1:0]  qry_tgt = '0;
    logic        qry_done;
    logic [31:0] qry_resp;

    logic [63:0] ring [256];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          reported = 0;
    int          n_evt = 0;
    int          n_spur = 0;
    logic [31:0] evq [1024];
    logic [31:0] last_ext;
    logic        last_bad;
    logic [3:0]  last_spt;
    int          wp = 0;
    logic [31:0] exp_resp [NT];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rd_entry = ring[rd_idx];

    rsp_ring_drain u_rsp_ring_drain (
        .clk(clk), .rst_n(rst_n), .hw_wp(hw_wp), .rd_idx(rd_idx), .rd_entry(rd_entry),
        .cmd_inc(cmd_inc), .cmd_tgt(cmd_tgt), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_resp(evt_resp), .evt_ext(evt_ext), .spur_valid(spur_valid),
        .spur_bad_tgt(spur_bad_tgt), .spur_tgt(spur_tgt), .qry_tgt(qry_tgt),
        .qry_done(qry_done), .qry_resp(qry_resp)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (evt_valid && evt_ready) begin
                if (n_evt < 1024) evq[n_evt] = evt_resp;
                last_ext = evt_ext;
                n_evt++;
            end
            if (spur_valid) begin
                n_spur++;
                last_bad = spur_bad_tgt;
                last_spt = spur_tgt;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] t);
        cmd_inc = 1'b1; cmd_tgt = t;
        cyc(1);
        cmd_inc = 1'b0;
    endtask

    task automatic push(input logic [31:0] ext, input logic [31:0] resp);
        wp = (wp + 1) % 256;
        ring[wp] = {ext, resp};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        int e0, s0;
        bit ord_ok;
        for (int i = 0; i < 256; i++) ring[i] = '0;
        for (int i = 0; i < NT; i++) exp_resp[i] = '0;
        cyc(3);
        // R10: reset state
        chk(rd_idx == 8'd1, "R10 rd_idx", rd_idx, 1);
        chk(!evt_valid && !spur_valid, "R10 outputs idle", {evt_valid, spur_valid}, 0);
        for (int t = 0; t < NT; t++) begin
            qry_tgt = 2'(t); #1;
            chk(qry_done && qry_resp == 0, "R10 query", {qry_done, qry_resp}, {1'b1, 32'h0});
        end
        rst_n = 1'b1;
        cyc(2);

        // Sweep every target code, flag value and pending state (R1, R4-R7, R9)
        for (int t = 0; t < 16; t++) begin
            for (int u = 0; u < 2; u++) begin
                for (int p = 0; p < ((t < NT) ? 2 : 1); p++) begin
                    logic [31:0] ext, resp;
                    ext  = {27'h5A5A5A5, u[0], t[3:0]};
                    resp = 32'hC0DE0000 | (t << 8) | (u << 4) | p;
                    if (p == 1) begin
                        issue(t[1:0]);
                        qry_tgt = t[1:0]; #1;
                        chk(!qry_done, "R9 pending not done", qry_done, 0);
                    end
                    e0 = n_evt; s0 = n_spur;
                    push(ext, resp);
                    hw_wp = 16'(wp);
                    cyc(4);
                    if (t >= NT) begin
                        chk(n_spur == s0 + 1 && last_bad && last_spt == t[3:0] && n_evt == e0,
                            "R5 bad target", {n_spur - s0, last_bad, last_spt}, {1, 1'b1, t[3:0]});
                    end else if (u == 1) begin
                        chk(n_evt == e0 + 1 && evq[e0] == resp && last_ext == ext && n_spur == s0,
                            "R4 R1 event", {evq[e0], last_ext}, {resp, ext});
                        if (p == 1) begin
                            qry_tgt = t[1:0]; #1;
                            chk(!qry_done, "R4 event does not retire", qry_done, 0);
                            // retire the pending command with a plain reply
                            push({27'h0, 1'b0, t[3:0]}, resp ^ 32'hFFFF);
                            hw_wp = 16'(wp);
                            cyc(4);
                            exp_resp[t] = resp ^ 32'hFFFF;
                        end
                    end else if (p == 1) begin
                        exp_resp[t] = resp;
                        qry_tgt = t[1:0]; #1;
                        chk(qry_done && qry_resp == resp && n_spur == s0, "R6 R9 reply stored",
                            {qry_done, qry_resp}, {1'b1, resp});
                    end else begin
                        qry_tgt = t[1:0]; #1;
                        chk(n_spur == s0 + 1 && !last_bad && qry_resp == exp_resp[t],
                            "R7 orphan discarded", {n_spur - s0, last_bad, qry_resp},
                            {1, 1'b0, exp_resp[t]});
                    end
                end
            end
        end

        // R2: long batch wrapping past slot 255, one slot per clock
        e0 = n_evt;
        for (int k = 0; k < 230; k++) push({27'h0, 1'b1, 4'd1}, 32'hE0000000 | k);
        @(negedge clk); hw_wp = 16'(wp);
        cyc(230);
        chk(n_evt == e0 + 229, "R2 rate one per clock", n_evt - e0, 229);
        cyc(1);
        chk(n_evt == e0 + 230, "R2 batch count", n_evt - e0, 230);
        ord_ok = 1;
        for (int k = 0; k < 230; k++) if (evq[e0 + k] != (32'hE0000000 | k)) ord_ok = 0;
        chk(ord_ok, "R2 wrap order", ord_ok, 1);
        chk(rd_idx == 8'(wp + 1), "R2 rd_idx after drain", rd_idx, 8'(wp + 1));

        // R4: stalled sink freezes the ring
        evt_ready = 1'b0;
        e0 = n_evt;
        for (int k = 0; k < 3; k++) push({27'h0, 1'b1, 4'd2}, 32'hBEEF0000 | k);
        hw_wp = 16'(wp);
        cyc(5);
        chk(n_evt == e0 && evt_valid && evt_resp == 32'hBEEF0000, "R4 stall holds",
            {n_evt - e0, evt_valid, evt_resp}, {0, 1'b1, 32'hBEEF0000});
        chk(rd_idx == 8'(wp - 2), "R4 rd_idx frozen", rd_idx, 8'(wp - 2));
        evt_ready = 1'b1;
        cyc(5);
        chk(n_evt == e0 + 3 && evq[e0 + 2] == 32'hBEEF0002, "R4 release", n_evt - e0, 3);

        // R3: all-ones pointer ignored
        e0 = n_evt; s0 = n_spur;
        push({27'h0, 1'b1, 4'd0}, 32'hA1);
        push({27'h0, 1'b0, 4'd0}, 32'hA2);
        hw_wp = 16'hFFFF;
        cyc(6);
        chk(n_evt == e0 && n_spur == s0 && rd_idx == 8'(wp - 1), "R3 dead pointer ignored",
            {n_evt - e0, rd_idx}, {0, 8'(wp - 1)});
        hw_wp = 16'(wp);
        cyc(5);
        chk(n_evt == e0 + 1 && n_spur == s0 + 1, "R3 resumes after valid pointer",
            {n_evt - e0, n_spur - s0}, {1, 1});

        // R8: increment coinciding with a decrement
        issue(2'd2); issue(2'd2);
        push({27'h0, 1'b0, 4'd2}, 32'h51);
        hw_wp = 16'(wp);
        cyc(1);
        cmd_inc = 1'b1; cmd_tgt = 2'd2;
        cyc(1);
        cmd_inc = 1'b0;
        cyc(3);
        qry_tgt = 2'd2; #1;
        chk(!qry_done && qry_resp == 32'h51, "R8 cancel keeps count", {qry_done, qry_resp}, {1'b0, 32'h51});
        push({27'h0, 1'b0, 4'd2}, 32'h52);
        hw_wp = 16'(wp);
        cyc(4);
        chk(!qry_done, "R8 one still pending", qry_done, 0);
        push({27'h0, 1'b0, 4'd2}, 32'h53);
        hw_wp = 16'(wp);
        cyc(4);
        chk(qry_done && qry_resp == 32'h53, "R8 R9 final done", {qry_done, qry_resp}, {1'b1, 32'h53});

        report();
    end

endmodule